// File: doc/BRIEF.md
# Floppy Drive Output Control Register

This block is the byte-wide host register that steers a floppy disk interface. A host writes one byte at a single I/O address. Two bits of the byte pick which one of four drives is selected. Four bits switch the four spindle motors. One bit holds the downstream disk controller in reset. One bit opens the DMA request, DMA acknowledge, terminal count and interrupt lines. The host can read the same byte back at any time.

The controller reset is active low and stays asserted while its bit holds 0. When the bit is written back to 1, a counter keeps the reset asserted for at least `RST_MIN_CYC` clock cycles. Two back-to-back writes (0, then 1) therefore still give a reset pulse that meets the minimum width. This reset reaches only the downstream controller; the register keeps its contents.

A mode input selects between AT-style and PS/2-style behaviour. In AT-style mode the DMA-enable bit controls the output enables of the request and interrupt lines, and it forces the incoming acknowledge and terminal count signals to 0 while they are disabled. In PS/2-style mode those lines are always enabled, and the bit is stored and read back but drives nothing. Access at the register is single-cycle, so the host bus has no handshake: a write strobe is taken on the clock edge where it is high.

Top module: `fdc_dout_ctl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the register holds 0x00. A read then returns 0x00, drive 0 is selected, all motors are off, `ctl_rst_n` is low, and in AT-style mode `drq_oe` and `irq_oe` are low.
- R2: Bits 1:0 hold a binary drive number n. Exactly one bit of `drv_sel` is high, and it is bit n.
- R3: While bit 2 holds 0, `ctl_rst_n` is low. After bit 2 is written to 1, `ctl_rst_n` goes high once the stretch count has run out.
- R4: A write with bit 2 = 0 followed on the very next cycle by a write with bit 2 = 1 keeps `ctl_rst_n` low for exactly `RST_MIN_CYC` cycles (20 by default).
- R5: Bits 7:4 drive `mtr_on[3:0]`: bit 4+i sets motor output i high.
- R6: When `mode_ps2` = 0 (AT-style mode), bit 3 = 1 sets `drq_oe` and `irq_oe` high and passes `dack_raw` and `tc_raw` through to `dack_core` and `tc_core`. Bit 3 = 0 sets both enables low and forces `dack_core` and `tc_core` to 0.
- R7: When `mode_ps2` = 1 (PS/2-style mode), the enables are high and acknowledge and terminal count pass through whatever bit 3 holds. Bit 3 is still stored, read back and cleared by reset.
- R8: Holding the controller in reset through bit 2 does not change any other bit of the register. The motors and the drive select keep their values for the whole time the reset is asserted.
- R9: A read at the register address returns the stored byte unchanged and has no side effect. A read at any other address returns 0x00.
- R10: A write takes effect only when `host_addr` equals `REG_ADDR` (default 0x3F2). Writes to other addresses leave all outputs and the stored byte unchanged.
- R11: Writing 0x1C, 0x2D, 0x4E or 0x8F selects drive 0, 1, 2 or 3 respectively. The same write turns on only that drive's motor, enables DMA and releases the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, asynchronous, active low |
| host_addr | input | ADDR_W | Host I/O address |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 8 | Read data, combinational, 0 when not selected |
| mode_ps2 | input | 1 | 1 = PS/2-style mode, 0 = AT-style mode |
| dack_raw | input | 1 | DMA acknowledge from the pin, active high |
| tc_raw | input | 1 | Terminal count from the pin, active high |
| drv_sel | output | 4 | One-hot drive select, active high |
| mtr_on | output | 4 | Motor enables, active high |
| ctl_rst_n | output | 1 | Reset to the disk controller, active low |
| drq_oe | output | 1 | Output enable for the DMA request pin |
| irq_oe | output | 1 | Output enable for the interrupt pin |
| dack_core | output | 1 | Gated DMA acknowledge to the controller |
| tc_core | output | 1 | Gated terminal count to the controller |

## Verification
A corrupted stored byte shows at the ports on the cycle after the write that caused it: through readback, through the one-hot select and through the motor outputs. A stretch counter that is loaded or decremented wrongly shows up only as a wrong length of the `ctl_rst_n` low pulse. For that reason the pulse is measured cycle by cycle after back-to-back writes. A fault in the mode gating is visible at once and combinationally on the output enables and on the gated acknowledge and terminal count. The bench checks each of these with `dack_raw` and `tc_raw` held high.

// File: rtl/fdc_dor_pkg.sv
package fdc_dor_pkg;
  localparam int unsigned NUM_DRV  = 4;
  localparam int unsigned SEL_W    = $clog2(NUM_DRV);
  localparam int unsigned BYTE_W   = 8;

  // Field layout of the control byte (software decodes these positions)
  typedef struct packed {
    logic [NUM_DRV-1:0] mtr;     // bits 7:4
    logic               dma_en;  // bit 3
    logic               nrst;    // bit 2, active-low controller reset
    logic [SEL_W-1:0]   drv;     // bits 1:0
  } dor_t;
endpackage

// File: rtl/fdc_dor_regs.sv
module fdc_dor_regs
  import fdc_dor_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(16'h3F2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rdata,
  output dor_t              q
);
  logic hit;
  assign hit = (addr == REG_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            q <= '0;
    else if (wr_en && hit) q <= dor_t'(wdata);
  end

  assign rdata = (rd_en && hit) ? BYTE_W'(q) : '0;

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && hit) |=> $stable(q)); // R9
  AST_WRITE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit) |=> (BYTE_W'(q) == $past(wdata))); // R10
endmodule

// File: rtl/fdc_drv_decode.sv
module fdc_drv_decode #(
  parameter int unsigned N     = 4,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic [N-1:0]     sel
);
  for (genvar i = 0; i < N; i++) begin : g_sel
    assign sel[i] = (idx == IDX_W'(i));
  end

  AST_SEL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel) == 1); // R2
endmodule

// File: rtl/fdc_rst_stretch.sv
module fdc_rst_stretch #(
  parameter int unsigned MIN_CYC = 20,
  localparam int unsigned CW     = $clog2(MIN_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_nrst,
  output logic ctl_rst_n
);
  localparam logic [CW-1:0] LOAD = CW'(MIN_CYC - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= LOAD;
    else if (!sw_nrst)   cnt <= LOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign ctl_rst_n = sw_nrst && (cnt == '0);

  if (MIN_CYC >= 2) begin : g_chk
    AST_RELEASE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_rst_n) |-> (sw_nrst && $past(sw_nrst))); // R4
  end
endmodule

// File: rtl/fdc_dma_gate.sv
module fdc_dma_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_ps2,
  input  logic dma_en,
  input  logic dack_raw,
  input  logic tc_raw,
  output logic drq_oe,
  output logic irq_oe,
  output logic dack_core,
  output logic tc_core
);
  logic open_q;
  assign open_q    = mode_ps2 | dma_en;
  assign drq_oe    = open_q;
  assign irq_oe    = open_q;
  assign dack_core = dack_raw & open_q;
  assign tc_core   = tc_raw & open_q;

  AST_DACK_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !drq_oe |-> (!dack_core && !tc_core)); // R6
  AST_PS2_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ps2 |-> (irq_oe && (dack_core == dack_raw))); // R7
endmodule

// File: rtl/fdc_dout_ctl.sv
module fdc_dout_ctl
  import fdc_dor_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(16'h3F2),
  parameter int unsigned RST_MIN_CYC = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [7:0]        host_rdata,
  input  logic              mode_ps2,
  input  logic              dack_raw,
  input  logic              tc_raw,
  output logic [3:0]        drv_sel,
  output logic [3:0]        mtr_on,
  output logic              ctl_rst_n,
  output logic              drq_oe,
  output logic              irq_oe,
  output logic              dack_core,
  output logic              tc_core
);
  dor_t q;

  fdc_dor_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(host_addr), .wdata(host_wdata),
    .wr_en(host_wr), .rd_en(host_rd), .rdata(host_rdata), .q(q)
  );

  fdc_drv_decode #(.N(NUM_DRV)) u_dec (
    .clk(clk), .rst_n(rst_n), .idx(q.drv), .sel(drv_sel)
  );

  fdc_rst_stretch #(.MIN_CYC(RST_MIN_CYC)) u_rst (
    .clk(clk), .rst_n(rst_n), .sw_nrst(q.nrst), .ctl_rst_n(ctl_rst_n)
  );

  fdc_dma_gate u_gate (
    .clk(clk), .rst_n(rst_n), .mode_ps2(mode_ps2), .dma_en(q.dma_en),
    .dack_raw(dack_raw), .tc_raw(tc_raw), .drq_oe(drq_oe), .irq_oe(irq_oe),
    .dack_core(dack_core), .tc_core(tc_core)
  );

  assign mtr_on = q.mtr;

  AST_SW_RST_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_rst_n && !host_wr) |=> $stable(mtr_on) && $stable(drv_sel)); // R8
endmodule

// File: tb/sim_fdc_dout_ctl.sv
`timescale 1ns/1ps
module sim_fdc_dout_ctl;
  localparam int unsigned AW = 16;
  localparam int unsigned MINC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] host_addr = 16'h3F2;
  logic [7:0] host_wdata = '0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_rdata;
  logic mode_ps2 = 1'b0, dack_raw = 1'b1, tc_raw = 1'b1;
  logic [3:0] drv_sel, mtr_on;
  logic ctl_rst_n, drq_oe, irq_oe, dack_core, tc_core;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fdc_dout_ctl #(.ADDR_W(AW), .RST_MIN_CYC(MINC)) u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .mode_ps2(mode_ps2), .dack_raw(dack_raw), .tc_raw(tc_raw),
    .drv_sel(drv_sel), .mtr_on(mtr_on), .ctl_rst_n(ctl_rst_n),
    .drq_oe(drq_oe), .irq_oe(irq_oe), .dack_core(dack_core), .tc_core(tc_core)
  );

  // {mode, wdata, exp drv_sel, exp mtr_on, exp oe}
  localparam int NV = 10;
  localparam logic [17:0] VECS [NV] = '{
    {1'b0, 8'h1C, 4'b0001, 4'b0001, 1'b1},  // R11 drive 0
    {1'b0, 8'h2D, 4'b0010, 4'b0010, 1'b1},  // R11 drive 1
    {1'b0, 8'h4E, 4'b0100, 4'b0100, 1'b1},  // R11 drive 2
    {1'b0, 8'h8F, 4'b1000, 4'b1000, 1'b1},  // R11 drive 3
    {1'b0, 8'hF4, 4'b0001, 4'b1111, 1'b0},  // R5 R6
    {1'b0, 8'h07, 4'b1000, 4'b0000, 1'b0},  // R2 R6
    {1'b1, 8'h07, 4'b1000, 4'b0000, 1'b1},  // R7
    {1'b1, 8'hA9, 4'b0010, 4'b1010, 1'b1},  // R7
    {1'b0, 8'hA9, 4'b0010, 4'b1010, 1'b1},  // R6
    {1'b0, 8'h52, 4'b0100, 4'b0101, 1'b0}   // R2 R5 R6
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    host_wr = 1'b0; host_addr = 16'h3F2;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    host_addr = a; host_rd = 1'b1; #0.5;
    d = host_rdata;
    host_rd = 1'b0; host_addr = 16'h3F2; #0.5;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int n;
    repeat (3) @(negedge clk);
    // R1 during reset
    rd(16'h3F2, r); chk(r, 8'h00, "R1 readback in reset");
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(16'h3F2, r); chk(r, 8'h00, "R1 readback after reset");
    chk({4'b0, drv_sel}, 8'h01, "R1 drv_sel");
    chk({4'b0, mtr_on}, 8'h00, "R1 mtr_on");
    chk({7'b0, ctl_rst_n}, 8'h00, "R1 ctl_rst_n low");
    chk({6'b0, drq_oe, irq_oe}, 8'h00, "R1 enables low");
    chk({6'b0, dack_core, tc_core}, 8'h00, "R6 dack/tc blocked after reset");

    // vector table
    for (int i = 0; i < NV; i++) begin
      mode_ps2 = VECS[i][17];
      wr(16'h3F2, VECS[i][16:9]);
      rd(16'h3F2, r); chk(r, VECS[i][16:9], "R9 readback");
      chk({4'b0, drv_sel}, {4'b0, VECS[i][8:5]}, "R2 drv_sel");
      chk({4'b0, mtr_on}, {4'b0, VECS[i][4:1]}, "R5 mtr_on");
      chk({6'b0, drq_oe, irq_oe}, {6'b0, VECS[i][0], VECS[i][0]}, "R6/R7 enables");
      chk({6'b0, dack_core, tc_core}, {6'b0, VECS[i][0], VECS[i][0]}, "R6/R7 dack tc");
    end
    mode_ps2 = 1'b0;

    // R4 back-to-back pulse width
    wr(16'h3F2, 8'h1C);
    repeat (MINC + 2) @(negedge clk);
    chk({7'b0, ctl_rst_n}, 8'h01, "R3 released");
    n = 0;
    wr(16'h3F2, 8'h18);
    if (!ctl_rst_n) n++;
    wr(16'h3F2, 8'h1C);
    while (!ctl_rst_n && n < 100) begin n++; @(negedge clk); end
    chk(8'(n), 8'(MINC), "R4 reset low width");

    // R3 / R8 held reset keeps other bits
    wr(16'h3F2, 8'hFB);
    repeat (MINC + 5) @(negedge clk);
    chk({7'b0, ctl_rst_n}, 8'h00, "R3 held low while bit2=0");
    rd(16'h3F2, r); chk(r, 8'hFB, "R8 other bits kept");
    chk({4'b0, mtr_on}, 8'h0F, "R8 motors kept");
    chk({4'b0, drv_sel}, 8'h08, "R8 select kept");
    wr(16'h3F2, 8'hFF);
    repeat (MINC + 1) @(negedge clk);
    chk({7'b0, ctl_rst_n}, 8'h01, "R3 release after 1");

    // R10 write elsewhere ignored
    wr(16'h03F0, 8'h00);
    wr(16'h13F2, 8'h00);
    rd(16'h3F2, r); chk(r, 8'hFF, "R10 foreign write ignored");
    chk({4'b0, mtr_on}, 8'h0F, "R10 motors unchanged");

    // R9 foreign read and no side effect
    rd(16'h03F4, r); chk(r, 8'h00, "R9 foreign read zero");
    rd(16'h3F2, r); rd(16'h3F2, r);
    @(negedge clk);
    chk({4'b0, drv_sel}, 8'h08, "R9 read no side effect");

    // R7 bit3 cleared by hw reset in PS/2 mode
    mode_ps2 = 1'b1;
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    rd(16'h3F2, r); chk(r, 8'h00, "R7 bit3 cleared by reset");
    chk({6'b0, drq_oe, irq_oe}, 8'h03, "R7 enables in PS/2 after reset");
    chk({6'b0, dack_core, tc_core}, 8'h03, "R7 dack tc pass PS/2");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule